// File: doc/BRIEF.md
# Serial NOR Flash Bus Slave

This block lets a host on a 32-bit shared bus see a serial NOR flash as a plain memory window. A bus read fetches the word stored at the addressed location. A bus write programs that word. Programming can only pull bits from 1 to 0, so a word must not be written twice without a whole-device erase in between. An internal SPI master turns every bus access into the serial instructions the flash needs.

The upper half of the address space is a one-word command register. Writing a fixed key to it starts a whole-device erase, which sets every bit to 1. Reading it returns a busy flag. While a program or an erase is still running inside the flash, any further flash-window access or command write is held off: its acknowledge is withheld until the device is idle again. The SPI clock is derived from the system clock by a parameter.

Top module: `sfl_flash_slave`

## Requirements
- R1: After a synchronous reset `spi_cs_n` is 1, `spi_sclk` is 0 and `bus_ack` is 0.
- R2: The host holds `bus_req` and its qualifiers until `bus_ack` rises. `bus_ack` is a one-cycle pulse per access. Only single accesses exist.
- R3: A read of flash word W (where `bus_addr` MSB is 0) issues opcode 0x03 and the 24-bit byte address 4*W, most significant byte first. It returns the four bytes from that address upward, with the first byte in bits 31:24.
- R4: A write to flash word W issues 0x06 in its own chip-select frame, then 0x02, the byte address 4*W and the four data bytes, bits 31:24 first. The stored word becomes the old word AND the written word.
- R5: After each program or erase the block repeats status-read frames (0x05 and one returned byte) until bit 0 of that byte is 0. No other instruction reaches the flash while that bit is set. A later flash access is acknowledged only after completion and sees the new contents.
- R6: Writing 0x0000_0A5E to the command register (`bus_addr` MSB is 1) issues 0x06 and then 0xC7. Afterwards every flash word reads 0xFFFF_FFFF.
- R7: A command-register write of any other value is acknowledged but sends no instruction to the flash, and leaves the flash contents unchanged.
- R8: A command-register read is acknowledged even while an operation runs. Bit 0 is 1 from the acknowledge of a program or erase until that operation finishes. Bits 31:1 are 0.
- R9: The SPI uses mode 0. `spi_sclk` is 0 whenever `spi_cs_n` is 1, and toggles only inside a frame. Each frame carries a whole number of bytes. The high phase of `spi_sclk` lasts exactly CLK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word address; MSB selects the command register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| spi_sclk | output | 1 | Serial clock to the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps every word of a 16-word flash model: first through reads of a known fill, then through programming over non-erased data, then through an erase and a second program pass. A design with the wrong byte order or address scaling returns swapped or misplaced words. A design that skips the write-enable leaves the model untouched. A design that overwrote instead of clearing bits returns the raw write data. A read issued right after a program catches a block that does not stall: the model flags any instruction other than a status read sent while it is busy. The bench also checks that the busy flag shows 1 immediately after an erase. Non-key command writes are checked by counting frames on the SPI pins and by re-reading data, which exposes a loose key compare.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
  localparam int BUS_W  = 32;
  localparam int FADR_W = 24;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'hC7;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [BUS_W-1:0] ERASE_KEY = 32'h0000_0A5E;
  typedef enum logic [1:0] {JOB_READ, JOB_PROG, JOB_ERASE} job_e;
endpackage

// File: rtl/sfl_spi_byte.sv
module sfl_spi_byte #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       last,
  input  logic [7:0] tx_byte,
  output logic       rdy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LIM = CW'(DIV - 1);

  typedef enum logic [1:0] {E_IDLE, E_LO, E_HI, E_GAP} est_e;
  est_e          st;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh, rx;
  logic          last_q;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st <= E_IDLE; cnt <= '0; bitn <= '0; sh <= '0; rx <= '0;
      last_q <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          sh <= tx_byte; last_q <= last; cs_n <= 1'b0;
          cnt <= '0; bitn <= '0; st <= E_LO;
        end
        E_LO: if (cnt == LIM) begin
          cnt <= '0; sclk <= 1'b1; rx <= {rx[6:0], miso}; st <= E_HI;
        end else cnt <= cnt + 1'b1;
        E_HI: if (cnt == LIM) begin
          cnt <= '0; sclk <= 1'b0;
          if (bitn == 3'd7) begin
            done <= 1'b1;
            if (last_q) begin cs_n <= 1'b1; st <= E_GAP; end
            else st <= E_IDLE;
          end else begin
            bitn <= bitn + 1'b1; sh <= {sh[6:0], 1'b0}; st <= E_LO;
          end
        end else cnt <= cnt + 1'b1;
        default: if (cnt == LIM) begin
          cnt <= '0; st <= E_IDLE;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign rdy     = (st == E_IDLE);
  assign mosi    = sh[7];
  assign rx_byte = rx;

  // R9: mode 0, clock parked low outside a frame
  a_r9_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R9: clock edges only while the frame was open
  a_r9_sclk_moves_in_frame: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> !$past(cs_n));
endmodule

// File: rtl/sfl_seq.sv
module sfl_seq
  import sfl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              go_read,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic [FADR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic              busy,
  output logic              rd_done,
  output logic [BUS_W-1:0]  rd_data,
  output logic              eng_start,
  output logic              eng_last,
  output logic [7:0]        eng_tx,
  input  logic              eng_rdy,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  typedef enum logic [1:0] {Q_IDLE, Q_WEN, Q_CMD, Q_POLL} qst_e;
  qst_e              st;
  job_e              job;
  logic [2:0]        idx, n_last;
  logic              wait_q;
  logic [FADR_W-1:0] addr_q;
  logic [BUS_W-1:0]  data_q, rd_q, dsh;

  assign n_last = (job == JOB_ERASE) ? 3'd0 : 3'd7;
  assign dsh    = data_q >> {3'd7 - idx, 3'b000};

  always_comb begin
    eng_tx   = 8'h00;
    eng_last = 1'b0;
    case (st)
      Q_WEN: begin eng_tx = OP_WREN; eng_last = 1'b1; end
      Q_POLL: begin eng_tx = idx[0] ? 8'h00 : OP_RDSR; eng_last = idx[0]; end
      Q_CMD: begin
        eng_last = (idx == n_last);
        case (idx)
          3'd0: eng_tx = (job == JOB_READ) ? OP_READ :
                         (job == JOB_PROG) ? OP_PROG : OP_ERASE;
          3'd1: eng_tx = addr_q[23:16];
          3'd2: eng_tx = addr_q[15:8];
          3'd3: eng_tx = addr_q[7:0];
          default: eng_tx = (job == JOB_PROG) ? dsh[7:0] : 8'h00;
        endcase
      end
      default: ;
    endcase
  end

  assign eng_start = (st != Q_IDLE) && !wait_q && eng_rdy;
  assign busy      = (st != Q_IDLE);
  assign rd_data   = rd_q;

  always_ff @(posedge clk) begin
    rd_done <= 1'b0;
    if (rst) begin
      st <= Q_IDLE; job <= JOB_READ; idx <= '0; wait_q <= 1'b0;
      addr_q <= '0; data_q <= '0; rd_q <= '0;
    end else begin
      if (eng_start) wait_q <= 1'b1;
      case (st)
        Q_IDLE: if (go_read || go_prog || go_erase) begin
          addr_q <= addr; data_q <= wdata; idx <= '0;
          job <= go_read ? JOB_READ : (go_prog ? JOB_PROG : JOB_ERASE);
          st  <= go_read ? Q_CMD : Q_WEN;
        end
        Q_WEN: if (eng_done) begin
          wait_q <= 1'b0; idx <= '0; st <= Q_CMD;
        end
        Q_CMD: if (eng_done) begin
          wait_q <= 1'b0;
          if (job == JOB_READ && idx[2]) rd_q <= {rd_q[23:0], eng_rx};
          if (idx == n_last) begin
            idx <= '0;
            if (job == JOB_READ) begin rd_done <= 1'b1; st <= Q_IDLE; end
            else st <= Q_POLL;
          end else idx <= idx + 1'b1;
        end
        default: if (eng_done) begin
          wait_q <= 1'b0;
          if (idx[0]) begin
            idx <= '0;
            if (!eng_rx[0]) st <= Q_IDLE;
          end else idx <= 3'd1;
        end
      endcase
    end
  end

  // R5: a new job is only taken while nothing is in flight
  a_r5_launch_when_idle: assert property (@(posedge clk) disable iff (rst)
    (go_read || go_prog || go_erase) |-> (st == Q_IDLE));
  // R5: at most one job request per cycle
  a_r5_one_launch: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_read, go_prog, go_erase}));
  // R4: program and erase never jump straight to the instruction frame
  a_r4_wren_first: assert property (@(posedge clk) disable iff (rst)
    (st == Q_CMD && $past(st) == Q_IDLE) |-> (job == JOB_READ));
endmodule

// File: rtl/sfl_flash_slave.sv
module sfl_flash_slave
  import sfl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ack,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int FW  = ADDR_W - 1;
  localparam int PAD = FADR_W - FW - 2;

  logic              cmd_hit, launched, pend_rd;
  logic              go_read, go_prog, go_erase;
  logic              seq_busy, rd_done;
  logic [BUS_W-1:0]  rd_data;
  logic [FADR_W-1:0] byte_addr;
  logic              e_start, e_last, e_rdy, e_done;
  logic [7:0]        e_tx, e_rx;

  assign cmd_hit   = bus_addr[ADDR_W-1];
  assign byte_addr = {{PAD{1'b0}}, bus_addr[FW-1:0], 2'b00};
  assign launched  = go_read | go_prog | go_erase;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_rdata <= '0; pend_rd <= 1'b0;
      go_read <= 1'b0; go_prog <= 1'b0; go_erase <= 1'b0;
    end else begin
      bus_ack <= 1'b0; go_read <= 1'b0; go_prog <= 1'b0; go_erase <= 1'b0;
      if (pend_rd) begin
        if (rd_done) begin
          bus_ack <= 1'b1; bus_rdata <= rd_data; pend_rd <= 1'b0;
        end
      end else if (bus_req && !bus_ack) begin
        if (cmd_hit && !bus_we) begin
          bus_ack <= 1'b1; bus_rdata <= {{(BUS_W-1){1'b0}}, seq_busy | launched};
        end else if (!seq_busy && !launched) begin
          if (cmd_hit) begin
            bus_ack <= 1'b1; bus_rdata <= '0;
            go_erase <= (bus_wdata == ERASE_KEY);
          end else if (bus_we) begin
            bus_ack <= 1'b1; bus_rdata <= '0; go_prog <= 1'b1;
          end else begin
            go_read <= 1'b1; pend_rd <= 1'b1;
          end
        end
      end
    end
  end

  sfl_seq seq_i (
    .clk(clk), .rst(rst), .go_read(go_read), .go_prog(go_prog), .go_erase(go_erase),
    .addr(byte_addr), .wdata(bus_wdata), .busy(seq_busy), .rd_done(rd_done),
    .rd_data(rd_data), .eng_start(e_start), .eng_last(e_last), .eng_tx(e_tx),
    .eng_rdy(e_rdy), .eng_done(e_done), .eng_rx(e_rx)
  );

  sfl_spi_byte #(.DIV(CLK_DIV)) eng_i (
    .clk(clk), .rst(rst), .start(e_start), .last(e_last), .tx_byte(e_tx),
    .rdy(e_rdy), .done(e_done), .rx_byte(e_rx), .sclk(spi_sclk),
    .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  // R2: acknowledge is a single-cycle pulse
  a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_ack |=> !bus_ack);
  // R8: command-register reads carry only the busy bit
  a_r8_cmd_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && $past(bus_req && !bus_we && cmd_hit && !pend_rd)) |-> (bus_rdata[BUS_W-1:1] == '0));
endmodule

// File: tb/sfl_flash_slave_tb.sv
module sfl_flash_slave_tb_top;
  localparam int ADDR_W  = 5;
  localparam int CLK_DIV = 2;
  localparam int NW      = 1 << (ADDR_W - 1);
  localparam int NB      = NW * 4;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(1 << (ADDR_W - 1));

  logic clk = 1'b0, rst = 1'b1;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  sfl_flash_slave #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0, bad = 0;
  bit done_f = 0;

  // ---------------- flash model ----------------
  logic [7:0]  fmem [NB];
  logic [7:0]  pp_buf [4];
  logic [7:0]  sh_in = '0, opc = '0;
  logic [23:0] fad = '0;
  int bitc = 0, busy_cnt = 0, op_count = 0, viol = 0, frame_err = 0, hp_err = 0, hi_cnt = 0;
  bit wel = 0, in_frame = 0;

  function automatic logic [7:0] init_b(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic out_bit();
    logic [7:0] b;
    b = 8'h00;
    if (opc == 8'h03 && bitc >= 32) b = fmem[(int'(fad) + (bitc - 32) / 8) % NB];
    else if (opc == 8'h05 && bitc >= 8) b = {6'b0, wel, busy_cnt != 0};
    return b[7 - (bitc % 8)];
  endfunction

  always @(negedge spi_cs_n) begin in_frame = 1; bitc = 0; opc = 8'h00; end

  always @(posedge spi_sclk) if (in_frame && spi_cs_n === 1'b0) begin
    sh_in = {sh_in[6:0], spi_mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      if (bitc == 8) opc = sh_in;
      else if (bitc <= 32) fad = {fad[15:0], sh_in};
      else if (opc == 8'h02 && bitc <= 64) pp_buf[bitc / 8 - 5] = sh_in;
    end
  end

  always @(negedge spi_sclk) if (in_frame && spi_cs_n === 1'b0) spi_miso = out_bit();

  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    if (bitc % 8 != 0) frame_err++;
    op_count++;
    if (busy_cnt != 0 && opc != 8'h05) viol++;
    case (opc)
      8'h06: wel = 1;
      8'h02: if (wel && bitc == 64 && busy_cnt == 0) begin
        for (int k = 0; k < 4; k++) fmem[(int'(fad) + k) % NB] &= pp_buf[k];
        busy_cnt = 3; wel = 0;
      end
      8'hC7: if (wel && busy_cnt == 0) begin
        for (int k = 0; k < NB; k++) fmem[k] = 8'hFF;
        busy_cnt = 6; wel = 0;
      end
      8'h05: if (busy_cnt > 0) busy_cnt--;
      default: ;
    endcase
  end

  // R9: high phase length
  always @(posedge clk) begin
    if (spi_sclk === 1'b1) hi_cnt++;
    else begin
      if (hi_cnt != 0 && hi_cnt != CLK_DIV) hp_err++;
      hi_cnt = 0;
    end
  end

  // ---------------- bench helpers ----------------
  logic [31:0] expw [NW];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, output logic [31:0] q);
    int n;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_ack && n < 20000);
    q = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] q);
    bus_op(1'b0, a, 32'h0, q);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus_op(1'b1, a, d, q);
  endtask

  task automatic wait_idle();
    logic [31:0] q;
    int n = 0;
    do begin rd(CMD_A, q); n++; end while (q[0] && n < 2000);
    chk("R8 busy clears", q, 32'h0);
  endtask

  task automatic sweep_read(input string tag);
    logic [31:0] q;
    for (int w = 0; w < NW; w++) begin
      rd(ADDR_W'(w), q);
      chk(tag, q, expw[w]);
    end
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] q, p;
    int oc;
    for (int i = 0; i < NB; i++) fmem[i] = init_b(i);
    for (int w = 0; w < NW; w++)
      expw[w] = {init_b(4*w), init_b(4*w+1), init_b(4*w+2), init_b(4*w+3)};
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'h1);
    chk("R1 sclk", {31'b0, spi_sclk}, 32'h0);
    chk("R1 ack",  {31'b0, bus_ack}, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle no frame", op_count, 0);

    // R8: idle status
    rd(CMD_A, q);
    chk("R8 idle status", q, 32'h0);
    // R2: ack is one cycle
    @(negedge clk);
    chk("R2 ack dropped", {31'b0, bus_ack}, 32'h0);

    // R3: read sweep of initial fill
    sweep_read("R3 initial read");

    // R4/R5: program over non-erased data, each followed by an immediate read
    for (int w = 0; w < NW; w++) begin
      p = (32'(w) * 32'h0102_0408) ^ 32'hF0F0_3C3C;
      wr(ADDR_W'(w), p);
      expw[w] = expw[w] & p;
      if (w == 0) begin
        rd(CMD_A, q);
        chk("R8 busy after program", q, 32'h1);
      end
      rd(ADDR_W'(w), q);
      chk("R5 stalled read after program", q, expw[w]);
    end
    sweep_read("R4 program AND sweep");

    // R7: non-key command writes do nothing
    for (int k = 0; k < 4; k++) begin
      p = (k == 0) ? 32'h0 : (k == 1) ? 32'h0000_00C7 : (k == 2) ? 32'h0000_0A5F : 32'hFFFF_FFFF;
      oc = op_count;
      wr(CMD_A, p);
      repeat (40) @(negedge clk);
      chk("R7 no instruction", op_count, oc);
      rd(CMD_A, q);
      chk("R7 status stays idle", q, 32'h0);
    end
    rd(ADDR_W'(3), q);
    chk("R7 contents kept", q, expw[3]);

    // R6: erase
    oc = op_count;
    wr(CMD_A, 32'h0000_0A5E);
    rd(CMD_A, q);
    chk("R8 busy after erase", q, 32'h1);
    wait_idle();
    chk("R6 erase frames issued", (op_count - oc) >= 3, 1);
    for (int w = 0; w < NW; w++) expw[w] = 32'hFFFF_FFFF;
    sweep_read("R6 erased sweep");

    // R4: program after erase
    for (int w = 0; w < NW; w++) begin
      p = 32'hA5C3_0000 | (32'(w) << 4) | 32'(NW - 1 - w);
      wr(ADDR_W'(w), p);
      expw[w] = p;
    end
    wait_idle();
    sweep_read("R4 program after erase");

    // R5 / R9 protocol bookkeeping observed at the pins
    chk("R5 no instruction while busy", viol, 0);
    chk("R9 whole bytes per frame", frame_err, 0);
    chk("R9 high phase length", hp_err, 0);
    chk("R9 sclk parked", {31'b0, spi_sclk}, 32'h0);
    finish_run();
  end
endmodule